// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block sequences the system reset for a processor supervisor. Two signals come in. The first is a supply-good flag from an external threshold comparator. The second is an active-low manual reset line from a pushbutton or other logic. The block drives the system reset outputs in three cases:

- while the supply is low;
- for a fixed stretch after the supply recovers;
- for a timed pulse after a manual reset press.

A watchdog can only reach the block through the manual reset line, by wiring its timeout output to that line. The block has no watchdog input of its own.

Both inputs come from outside the clock domain, so each passes through a synchronizer. The manual line then goes through a falling-edge detector. A state machine with three states owns the reset decision:

- `ST_HOLD`: supply low, reset asserted.
- `ST_STRETCH`: reset asserted while the period counter runs.
- `ST_RUN`: reset released.

The named transitions are:

- `T_SUPPLY_LOST`: any state goes to `ST_HOLD` when the synchronized supply flag is low.
- `T_SUPPLY_BACK`: `ST_HOLD` goes to `ST_STRETCH` once the supply flag is high, with the counter cleared.
- `T_MANUAL`: `ST_RUN` goes to `ST_STRETCH` on a manual falling edge.
- `T_RESTART`: `ST_STRETCH` stays in `ST_STRETCH` on a manual falling edge, and the counter clears.
- `T_EXPIRE`: `ST_STRETCH` goes to `ST_RUN` when the counter reaches the end of the period.

The period, the synchronizer depth and the output polarity set are parameters. The output polarity set is one of: active-high only, active-low only, or both.

Top module: `sup_rst_seq`

## Requirements
- R1: While `supply_ok` is low, reset is asserted (`sys_rst_n_o`=0). After a high-to-low change of `supply_ok`, reset is asserted SYNC_STAGES+1 clock edges after the change, and it stays asserted for as long as the input stays low.
- R2: After `supply_ok` rises, reset is released exactly SYNC_STAGES+1+PERIOD_CYCLES clock edges after the change.
- R3: A supply loss during an active reset period discards the remaining count. Release then follows the supply recovery by the full R2 delay.
- R4: A 1-to-0 change of `man_rst_n` while reset is released asserts reset SYNC_STAGES+1 edges later, for exactly PERIOD_CYCLES cycles.
- R5: Holding `man_rst_n` low longer than the period yields one pulse only. Reset is released at the end of the period even though the input is still low.
- R6: A new falling edge of `man_rst_n` during an active pulse restarts the count. A bouncing line therefore gives one longer pulse that ends PERIOD_CYCLES cycles after the last synchronized fall, and no extra release/assert pair.
- R7: Falling edges of `man_rst_n` while the supply is low have no effect. Release follows supply recovery by the R2 delay.
- R8: When a supply loss and a manual falling edge arrive together while reset is released, the supply loss wins. Release then follows supply recovery by the R2 delay.
- R9: With OUT_MODE = OUT_BOTH, `sys_rst_o` is the exact inverse of `sys_rst_n_o` in every cycle. In a single-output mode the unused output sits at its inactive level (`sys_rst_n_o`=1 or `sys_rst_o`=0).
- R10: While `por_n` is low, both outputs show reset asserted (`sys_rst_n_o`=0, `sys_rst_o`=1) and the period counter is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| por_n | input | 1 | Asynchronous power-on clear, active low |
| supply_ok | input | 1 | Supply-above-threshold flag from the external comparator (asynchronous) |
| man_rst_n | input | 1 | Manual reset request, active low, falling-edge triggered (asynchronous) |
| sys_rst_n_o | output | 1 | System reset, active low |
| sys_rst_o | output | 1 | System reset, active high |

## Verification
The hardest situation to reach from the ports is a bouncing manual line whose later falls land inside a running pulse. The fall detector must re-arm between bounces, and each fall must reach the state machine before the period expires.

The stimulus releases and re-presses the line in steps longer than the synchronizer depth. The last fall lands shortly before the original period would end. The expected release moves to the last fall, so an early release or a second pulse shows up as a mismatch.

A brownout placed in the middle of a pulse, and a supply drop that coincides with a press, cover the priority paths in the same way.

// File: rtl/sup_rst_pkg.sv
package sup_rst_pkg;

    typedef enum logic [1:0] {
        ST_HOLD    = 2'd0,
        ST_STRETCH = 2'd1,
        ST_RUN     = 2'd2
    } seq_state_t;

    typedef enum logic [1:0] {
        OUT_HIGH_ONLY = 2'd0,
        OUT_LOW_ONLY  = 2'd1,
        OUT_BOTH      = 2'd2
    } out_mode_t;

endpackage

// File: rtl/sup_rst_sync.sv
module sup_rst_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic por_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge por_n) begin
                    if (!por_n) chain[0] <= RESET_VAL;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge por_n) begin
                    if (!por_n) chain[i] <= RESET_VAL;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/sup_rst_edge.sv
module sup_rst_edge (
    input  logic clk,
    input  logic por_n,
    input  logic level,
    output logic fall
);
    logic level_d;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) level_d <= 1'b1;
        else        level_d <= level;
    end

    assign fall = level_d & ~level;

    // R6: a fall indication lasts one cycle, so one press gives one event
    a_r6_single_fall: assert property (@(posedge clk) disable iff (!por_n)
        fall |=> !fall);

endmodule

// File: rtl/sup_rst_timer.sv
module sup_rst_timer #(
    parameter int LIMIT = 20_000_000
) (
    input  logic clk,
    input  logic por_n,
    input  logic clr,
    input  logic en,
    output logic done
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)               cnt <= '0;
        else if (clr)             cnt <= '0;
        else if (en && cnt != LAST) cnt <= cnt + 1'b1;
    end

    assign done = (cnt == LAST);

    // R2: the count never passes the end of the period
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!por_n)
        cnt <= LAST);
    // R6: a clear request always restarts from zero
    a_r6_clear_zero: assert property (@(posedge clk) disable iff (!por_n)
        clr |=> cnt == '0);

endmodule

// File: rtl/sup_rst_fsm.sv
module sup_rst_fsm
    import sup_rst_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic supply_good,
    input  logic man_fall,
    input  logic period_done,
    output logic timer_clr,
    output logic timer_en,
    output logic rst_active
);
    seq_state_t state, state_nxt;

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state <= ST_HOLD;
        else        state <= state_nxt;
    end

    // next-state decision
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_HOLD: begin
                if (supply_good) state_nxt = ST_STRETCH;      // T_SUPPLY_BACK
            end
            ST_STRETCH: begin
                if (!supply_good)     state_nxt = ST_HOLD;    // T_SUPPLY_LOST
                else if (man_fall)    state_nxt = ST_STRETCH; // T_RESTART
                else if (period_done) state_nxt = ST_RUN;     // T_EXPIRE
            end
            ST_RUN: begin
                if (!supply_good)  state_nxt = ST_HOLD;       // T_SUPPLY_LOST
                else if (man_fall) state_nxt = ST_STRETCH;    // T_MANUAL
            end
            default: state_nxt = ST_HOLD;
        endcase
    end

    // outputs decoded from the state register
    always_comb begin
        timer_clr  = 1'b1;
        timer_en   = 1'b0;
        rst_active = 1'b1;
        unique case (state)
            ST_HOLD: begin
                timer_clr  = 1'b1;
                rst_active = 1'b1;
            end
            ST_STRETCH: begin
                timer_clr  = man_fall;
                timer_en   = 1'b1;
                rst_active = 1'b1;
            end
            ST_RUN: begin
                timer_clr  = 1'b1;
                rst_active = 1'b0;
            end
            default: begin
                timer_clr  = 1'b1;
                rst_active = 1'b1;
            end
        endcase
    end

    // R1: a low supply flag forces reset on the next cycle
    a_r1_low_supply: assert property (@(posedge clk) disable iff (!por_n)
        !supply_good |=> rst_active);
    // R2: release only happens at the end of a completed period
    a_r2_release_done: assert property (@(posedge clk) disable iff (!por_n)
        $fell(rst_active) |-> $past(period_done));
    // R4: a manual fall with good supply while released asserts reset
    a_r4_manual_asserts: assert property (@(posedge clk) disable iff (!por_n)
        (!rst_active && supply_good && man_fall) |=> rst_active);
    // R8: supply loss wins over a simultaneous manual fall
    a_r8_supply_first: assert property (@(posedge clk) disable iff (!por_n)
        (!supply_good && man_fall) |=> state == ST_HOLD);

endmodule

// File: rtl/sup_rst_drive.sv
module sup_rst_drive
    import sup_rst_pkg::*;
#(
    parameter out_mode_t OUT_MODE = OUT_BOTH
) (
    input  logic clk,
    input  logic por_n,
    input  logic rst_active,
    output logic rst_n_out,
    output logic rst_out
);
    generate
        if (OUT_MODE == OUT_BOTH) begin : g_both
            assign rst_n_out = ~rst_active;
            assign rst_out   = rst_active;
            // R9: the two outputs are always complementary
            a_r9_complement: assert property (@(posedge clk) disable iff (!por_n)
                rst_out != rst_n_out);
        end else if (OUT_MODE == OUT_HIGH_ONLY) begin : g_high
            assign rst_n_out = 1'b1;
            assign rst_out   = rst_active;
        end else begin : g_low
            assign rst_n_out = ~rst_active;
            assign rst_out   = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/sup_rst_seq.sv
module sup_rst_seq
    import sup_rst_pkg::*;
#(
    parameter int        PERIOD_CYCLES = 20_000_000,
    parameter int        SYNC_STAGES   = 2,
    parameter out_mode_t OUT_MODE      = OUT_BOTH
) (
    input  logic clk,
    input  logic por_n,
    input  logic supply_ok,
    input  logic man_rst_n,
    output logic sys_rst_n_o,
    output logic sys_rst_o
);
    logic supply_good;
    logic man_level;
    logic man_fall;
    logic period_done;
    logic timer_clr;
    logic timer_en;
    logic rst_active;

    sup_rst_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_supply (
        .clk(clk), .por_n(por_n), .d(supply_ok), .q(supply_good)
    );

    sup_rst_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_manual (
        .clk(clk), .por_n(por_n), .d(man_rst_n), .q(man_level)
    );

    sup_rst_edge u_edge (
        .clk(clk), .por_n(por_n), .level(man_level), .fall(man_fall)
    );

    sup_rst_timer #(.LIMIT(PERIOD_CYCLES)) u_timer (
        .clk(clk), .por_n(por_n), .clr(timer_clr), .en(timer_en),
        .done(period_done)
    );

    sup_rst_fsm u_fsm (
        .clk(clk), .por_n(por_n), .supply_good(supply_good),
        .man_fall(man_fall), .period_done(period_done),
        .timer_clr(timer_clr), .timer_en(timer_en), .rst_active(rst_active)
    );

    sup_rst_drive #(.OUT_MODE(OUT_MODE)) u_drive (
        .clk(clk), .por_n(por_n), .rst_active(rst_active),
        .rst_n_out(sys_rst_n_o), .rst_out(sys_rst_o)
    );

    // R10: during power-on clear the outputs show reset asserted
    always_comb begin
        if (!por_n && OUT_MODE != OUT_HIGH_ONLY)
            a_r10_por_low: assert (sys_rst_n_o == 1'b0);
    end

endmodule

// File: tb/sup_rst_seq_bench.sv
module sup_rst_seq_bench;

    localparam int PER = 40;
    localparam int SYN = 2;
    localparam int LAT = SYN + 1;

    typedef struct {
        bit    lvl;
        int    cyc;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic supply_ok = 1'b0;
    logic man_rst_n = 1'b1;
    logic sys_rst_n_o, sys_rst_o;

    int ecnt = 0;
    int checks = 0;
    int failures = 0;
    int inv_bad = 0;
    bit mon_on = 1'b0;
    bit last_lvl = 1'b0;
    exp_t expq[$];

    sup_rst_seq #(.PERIOD_CYCLES(PER), .SYNC_STAGES(SYN)) u_sup_rst_seq (
        .clk(clk), .por_n(por_n), .supply_ok(supply_ok),
        .man_rst_n(man_rst_n), .sys_rst_n_o(sys_rst_n_o), .sys_rst_o(sys_rst_o)
    );

    always #5 clk = ~clk;
    always @(posedge clk) ecnt <= ecnt + 1;

    task automatic push(input bit lvl, input int cyc, input string tag);
        exp_t e;
        e.lvl = lvl; e.cyc = cyc; e.tag = tag;
        expq.push_back(e);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
        end
    endtask

    // monitor: pops expected transitions as the output changes
    always @(negedge clk) begin
        if (mon_on) begin
            if (sys_rst_o !== ~sys_rst_n_o) inv_bad++;
            if (sys_rst_n_o !== last_lvl) begin
                if (expq.size() == 0) begin
                    check(1'b0, "unexpected output change", ecnt, -1);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    check(sys_rst_n_o === e.lvl, {e.tag, " level"}, int'(sys_rst_n_o), int'(e.lvl));
                    check(ecnt == e.cyc, {e.tag, " cycle"}, ecnt, e.cyc);
                end
                last_lvl = sys_rst_n_o;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=0", ecnt);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int e0, e1, e2;
        // R10: power-on state
        step(3);
        check(sys_rst_n_o == 1'b0, "R10 rst_n during por", int'(sys_rst_n_o), 0);
        check(sys_rst_o == 1'b1, "R10 rst during por", int'(sys_rst_o), 1);
        por_n = 1'b1;
        last_lvl = 1'b0;
        mon_on = 1'b1;
        step(20); // R1: supply low keeps reset asserted (no change expected)

        // R2: supply recovery
        supply_ok = 1'b1; push(1'b1, ecnt + LAT + PER, "R2 power-up release");
        step(LAT + PER + 20);

        // R4/R5: press held well past the period
        man_rst_n = 1'b0; e0 = ecnt;
        push(1'b0, e0 + LAT, "R4 manual assert");
        push(1'b1, e0 + LAT + PER, "R5 release while held");
        step(3 * PER);
        man_rst_n = 1'b1; step(20);

        // R6: bouncing press restarts the period
        man_rst_n = 1'b0; e0 = ecnt; push(1'b0, e0 + LAT, "R6 bounce assert");
        step(8); man_rst_n = 1'b1; step(8); man_rst_n = 1'b0;
        step(8); man_rst_n = 1'b1; step(8); man_rst_n = 1'b0; e2 = ecnt;
        push(1'b1, e2 + LAT + PER, "R6 release after last fall");
        step(LAT + PER + 10);
        man_rst_n = 1'b1; step(20);

        // R3: brownout inside an active pulse
        man_rst_n = 1'b0; e0 = ecnt; push(1'b0, e0 + LAT, "R4 assert before brownout");
        step(6); man_rst_n = 1'b1; step(4);
        supply_ok = 1'b0; step(10);
        supply_ok = 1'b1; e1 = ecnt; push(1'b1, e1 + LAT + PER, "R3 full period after brownout");
        step(LAT + PER + 20);

        // R1/R7: supply drop while running, presses ignored
        supply_ok = 1'b0; e0 = ecnt; push(1'b0, e0 + LAT, "R1 assert on supply loss");
        step(30); man_rst_n = 1'b0; step(10); man_rst_n = 1'b1; step(10);
        man_rst_n = 1'b0; step(10); man_rst_n = 1'b1; step(40);
        supply_ok = 1'b1; e1 = ecnt; push(1'b1, e1 + LAT + PER, "R7 release after recovery");
        step(LAT + PER + 20);

        // R1/R2: one-cycle supply glitch
        supply_ok = 1'b0; e0 = ecnt; push(1'b0, e0 + LAT, "R1 glitch assert");
        step(1); supply_ok = 1'b1; e1 = ecnt; push(1'b1, e1 + LAT + PER, "R2 glitch release");
        step(LAT + PER + 20);

        // R8: supply loss together with a press
        supply_ok = 1'b0; man_rst_n = 1'b0; e0 = ecnt;
        push(1'b0, e0 + LAT, "R8 simultaneous assert");
        step(10); man_rst_n = 1'b1; step(10);
        supply_ok = 1'b1; e1 = ecnt; push(1'b1, e1 + LAT + PER, "R8 release after recovery");
        step(LAT + PER + 20);

        check(expq.size() == 0, "R2 all expected transitions seen", expq.size(), 0);
        check(inv_bad == 0, "R9 outputs complementary", inv_bad, 0);
        check(sys_rst_n_o == 1'b1, "R4 final released", int'(sys_rst_n_o), 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule